// File: doc/BRIEF.md
# Interrupt Service Latency Meter

This block is programmable-logic instrumentation that measures how long a processor takes to respond to an interrupt. An internal pulse-width generator produces a periodic square wave that needs no software involvement. A change detector watches that wave and raises an interrupt request on every transition, whether rising or falling. At the moment the request is raised, a free-running 32-bit cycle counter is sampled into a start timestamp.

Software runs its service routine and, from inside it, sets a dedicated "service done" bit in the control word. The 0-to-1 change of that bit samples the counter a second time. The block keeps both timestamps and their difference in a small register bank, so software can read the latency directly. The stimulus, the request and the service-done bit also drive debug pins for an external logic analyzer, and a further control bit drives an LED.

Top module: `irq_lat_meter`

## Requirements
- R1: After reset every register reads 0, and irq, dbg_stim, dbg_irq, dbg_ack and led are all low.
- R2: The stimulus drives dbg_stim. With CTRL bit 0 (enable) set, dbg_stim is high for HIGH cycles and then low for PERIOD-HIGH cycles, repeating. It stays constantly high when HIGH>=PERIOD or PERIOD<=1 (with HIGH>0). It stays constantly low when HIGH=0 or when enable is clear, and it is low in the cycle after enable is seen clear.
- R3: Every change of dbg_stim, rising or falling, sets irq one cycle after the change appears on dbg_stim.
- R4: irq stays set until a write to STATUS (address 1) with bit 0 set clears it. A STATUS write with bit 0 clear leaves irq unchanged.
- R5: A stimulus change while irq is set sets the overrun flag (STATUS bit 1). The flag clears only when STATUS is written with bit 1 set.
- R6: Each raised request samples the free-running counter into TSTART (address 4). The difference between two successive TSTART values equals the number of cycles between the two stimulus changes.
- R7: A 0-to-1 write of CTRL bit 1 (service done) while a measurement is armed (STATUS bit 3) captures TSTOP (address 5) and sets LATENCY (address 6) to TSTOP-TSTART modulo 2^32. It also sets valid (STATUS bit 2) and clears armed. If the write lands d cycles after the cycle in which irq first reads high, LATENCY is d+1.
- R8: A service-done rising edge with no armed measurement is ignored: TSTOP, LATENCY and valid keep their values.
- R9: A new start while a measurement is armed restarts it: TSTART is re-sampled, valid is cleared, armed stays set and overrun is set.
- R10: dbg_irq follows irq, dbg_ack follows CTRL bit 1, and led follows CTRL bit 2.
- R11: A read strobe loads reg_rdata with the addressed word at the next clock edge. The map is CTRL 0, STATUS 1, PERIOD 2, HIGH 3, TSTART 4, TSTOP 5 and LATENCY 6. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the timestamp time base |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| irq | output | 1 | Interrupt request to the processor |
| dbg_stim | output | 1 | Stimulus waveform mirror |
| dbg_irq | output | 1 | Interrupt request mirror |
| dbg_ack | output | 1 | Service-done bit mirror |
| led | output | 1 | Progress indicator |

## Verification
The assertions assume that the only write traffic is single-cycle strobes from one master. They also assume that interrupt clears and service-done writes arrive only as register writes, so every fall of irq and every rise of valid can be traced to a specific write one cycle earlier. The bench holds reset for several cycles, so the two-cycle look-back on the stimulus never reaches undefined values. In the latency and overrun phases it sets the stimulus period to 1000 cycles, which keeps each acknowledge sequence well inside one half period; a falling edge stays in the gap between measurements. The only deliberate violations are the overrun and restart scenarios, which the checker's flag assertions are written to accept.

// File: rtl/ilm_pkg.sv
// Shared address map and status bit positions for the interrupt latency meter.
// Assumes a word-addressed register bank with a 3-bit address.
package ilm_pkg;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
    localparam logic [ADDR_W-1:0] A_PERIOD = 3'd2;
    localparam logic [ADDR_W-1:0] A_HIGH   = 3'd3;
    localparam logic [ADDR_W-1:0] A_TSTART = 3'd4;
    localparam logic [ADDR_W-1:0] A_TSTOP  = 3'd5;
    localparam logic [ADDR_W-1:0] A_LAT    = 3'd6;
    // control word bit positions
    localparam int C_EN   = 0;
    localparam int C_DONE = 1;
    localparam int C_LED  = 2;
    // status word bit positions
    localparam int S_IRQ   = 0;
    localparam int S_OVR   = 1;
    localparam int S_VALID = 2;
    localparam int S_ARMED = 3;
endpackage

// File: rtl/ilm_pwm.sv
// Periodic stimulus generator. Output is high for `high` cycles of every
// `period` cycles while enabled; forced low when disabled. Assumes the
// period and high values may change at any time; the phase counter wraps
// safely when the period shrinks below it.
module ilm_pwm #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] period,
    input  logic [W-1:0] high,
    output logic         out_q
);
    logic [W-1:0] phase_q;
    logic [W:0]   phase_nxt;

    assign phase_nxt = {1'b0, phase_q} + 1'b1;

    // phase counter: restarts at 0 when disabled or at the end of a period
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            phase_q <= '0;
        end else if (phase_nxt >= {1'b0, period}) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_nxt[W-1:0];
        end
    end

    // registered waveform: high while the phase is below the high time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else begin
            out_q <= en && (phase_q < high);
        end
    end
endmodule

// File: rtl/ilm_irq_gen.sv
// Change detector and interrupt request holder. Any transition of the
// stimulus (either direction) produces a one-cycle start pulse and sets the
// request, which is held until cleared. Overrun is flagged when a change
// arrives while the request is pending or when the capture unit restarts.
// Assumes the stimulus is synchronous to clk.
module ilm_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic stim,
    input  logic clr_irq,
    input  logic clr_ovr,
    input  logic restart,
    output logic start_o,
    output logic irq_q,
    output logic ovr_q
);
    logic stim_d;

    assign start_o = stim ^ stim_d;

    // delayed copy of the stimulus for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) stim_d <= 1'b0;
        else        stim_d <= stim;
    end

    // request holder: a change sets it, a software clear drops it
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_q <= 1'b0;
        else if (start_o)  irq_q <= 1'b1;
        else if (clr_irq)  irq_q <= 1'b0;
    end

    // overrun flag: set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                              ovr_q <= 1'b0;
        else if ((start_o && irq_q) || restart)  ovr_q <= 1'b1;
        else if (clr_ovr)                        ovr_q <= 1'b0;
    end
endmodule

// File: rtl/ilm_capture.sv
// Free-running cycle counter with start/stop timestamp capture. A start
// arms a measurement and clears valid; a stop while armed records the stop
// time and the modular difference. A stop with nothing armed is ignored.
// A start while armed restarts the measurement and reports it on restart_o.
// Start takes priority when both arrive in the same cycle.
module ilm_capture #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          stop,
    output logic [CW-1:0] tstart_q,
    output logic [CW-1:0] tstop_q,
    output logic [CW-1:0] lat_q,
    output logic          valid_q,
    output logic          armed_q,
    output logic          restart_o
);
    logic [CW-1:0] cnt_q;

    assign restart_o = start && armed_q;

    // time base: counts every clock, wraps modulo 2^CW
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // measurement state and timestamps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tstart_q <= '0;
            tstop_q  <= '0;
            lat_q    <= '0;
            valid_q  <= 1'b0;
            armed_q  <= 1'b0;
        end else if (start) begin
            tstart_q <= cnt_q;
            armed_q  <= 1'b1;
            valid_q  <= 1'b0;
        end else if (stop && armed_q) begin
            tstop_q <= cnt_q;
            lat_q   <= cnt_q - tstart_q;
            valid_q <= 1'b1;
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_lat_meter.sv
// Interrupt service latency meter top level. Holds the register bank,
// ties the stimulus generator, change detector and capture unit together,
// and mirrors key signals to debug pins. Assumes single-cycle read/write
// strobes from one master; read data appears one clock after the strobe.
module irq_lat_meter #(
    parameter int DW    = 32,
    parameter int PWM_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic                       reg_rd,
    input  logic [ilm_pkg::ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]              reg_wdata,
    output logic [DW-1:0]              reg_rdata,
    output logic                       irq,
    output logic                       dbg_stim,
    output logic                       dbg_irq,
    output logic                       dbg_ack,
    output logic                       led
);
    import ilm_pkg::*;

    logic             en_q, done_q, led_q;
    logic [PWM_W-1:0] period_q, high_q;
    logic             stim, start, stop, restart;
    logic             irq_q, ovr_q, valid_q, armed_q;
    logic [DW-1:0]    tstart_q, tstop_q, lat_q;
    logic             wr_ctrl, wr_stat;
    logic [DW-1:0]    rd_mux;

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_stat = reg_wr && (reg_addr == A_STATUS);
    assign stop    = wr_ctrl && reg_wdata[C_DONE] && !done_q;

    // control and stimulus configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            done_q   <= 1'b0;
            led_q    <= 1'b0;
            period_q <= '0;
            high_q   <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    en_q   <= reg_wdata[C_EN];
                    done_q <= reg_wdata[C_DONE];
                    led_q  <= reg_wdata[C_LED];
                end
                A_PERIOD: period_q <= reg_wdata[PWM_W-1:0];
                A_HIGH:   high_q   <= reg_wdata[PWM_W-1:0];
                default: ;
            endcase
        end
    end

    ilm_pwm #(.W(PWM_W)) u_pwm (
        .clk(clk), .rst_n(rst_n), .en(en_q),
        .period(period_q), .high(high_q), .out_q(stim)
    );

    ilm_irq_gen u_irq (
        .clk(clk), .rst_n(rst_n), .stim(stim),
        .clr_irq(wr_stat && reg_wdata[S_IRQ]),
        .clr_ovr(wr_stat && reg_wdata[S_OVR]),
        .restart(restart), .start_o(start), .irq_q(irq_q), .ovr_q(ovr_q)
    );

    ilm_capture #(.CW(DW)) u_cap (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .tstart_q(tstart_q), .tstop_q(tstop_q), .lat_q(lat_q),
        .valid_q(valid_q), .armed_q(armed_q), .restart_o(restart)
    );

    // read multiplexer over the word map; unmapped words read zero
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            A_CTRL:   begin
                rd_mux[C_EN]   = en_q;
                rd_mux[C_DONE] = done_q;
                rd_mux[C_LED]  = led_q;
            end
            A_STATUS: begin
                rd_mux[S_IRQ]   = irq_q;
                rd_mux[S_OVR]   = ovr_q;
                rd_mux[S_VALID] = valid_q;
                rd_mux[S_ARMED] = armed_q;
            end
            A_PERIOD: rd_mux = DW'(period_q);
            A_HIGH:   rd_mux = DW'(high_q);
            A_TSTART: rd_mux = tstart_q;
            A_TSTOP:  rd_mux = tstop_q;
            A_LAT:    rd_mux = lat_q;
            default:  rd_mux = '0;
        endcase
    end

    // registered read data, loaded on the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

    assign irq      = irq_q;
    assign dbg_irq  = irq_q;
    assign dbg_stim = stim;
    assign dbg_ack  = done_q;
    assign led      = led_q;
endmodule

// File: rtl/ilm_checker.sv
// Temporal checks for the interrupt latency meter, bound to the top level.
// Assumes reset is held for at least two cycles at start-up.
module ilm_checker #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          irq,
    input logic          dbg_stim,
    input logic          dbg_ack,
    input logic          en_q,
    input logic          ovr_q,
    input logic          valid_q,
    input logic          armed_q,
    input logic [DW-1:0] lat_q
);
    // R2: disabled generator yields a low stimulus in the next cycle
    a_r2_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !dbg_stim);

    // R3: a rising request is preceded by a stimulus change
    a_r3_edge_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(dbg_stim) != $past(dbg_stim, 2)));

    // R4: the request only drops after a clearing write to STATUS
    a_r4_irq_clear_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr && reg_addr == 3'd1 && reg_wdata[0]));

    // R5, R9: overrun only appears when a request or measurement was pending
    a_r5_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> $past(irq || armed_q));

    // R7: a fresh result coincides with the service-done bit rising
    a_r7_valid_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $rose(dbg_ack));

    // R8: a held result keeps its latency
    a_r8_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && $past(valid_q)) |-> $stable(lat_q));

    // R9: a measurement is never armed and valid at once
    a_r9_armed_xor_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed_q && valid_q));
endmodule

bind irq_lat_meter ilm_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .dbg_stim(dbg_stim), .dbg_ack(dbg_ack),
    .en_q(en_q), .ovr_q(ovr_q), .valid_q(valid_q), .armed_q(armed_q),
    .lat_q(lat_q)
);

// File: tb/irq_lat_meter_bench.sv
// Self-checking bench: sweeps small stimulus settings, then measures a
// range of service delays and the overrun/restart and ignore cases.
module irq_lat_meter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, dbg_stim, dbg_irq, dbg_ack, led;

    int checks = 0;
    int fails  = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    irq_lat_meter u_irq_lat_meter (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .dbg_stim(dbg_stim), .dbg_irq(dbg_irq),
        .dbg_ack(dbg_ack), .led(led)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // callers are at a negedge; both tasks return at a negedge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wait_stim_change();
        logic s0;
        s0 = dbg_stim;
        while (dbg_stim == s0) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, t0, t1;
        int ones, zeros;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R11: reset state of every word and pin; address 7 reads zero
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk($sformatf("R1/R11 reset word %0d", a), v, 32'h0);
        end
        chk("R1 pins", {27'b0, irq, dbg_stim, dbg_irq, dbg_ack, led}, 32'h0);

        // R8: done rising with nothing armed is ignored; R10 pin mirrors
        wr(3'd0, 32'h2);
        chk("R10 dbg_ack follows done", {31'b0, dbg_ack}, 32'h1);
        rd(3'd1, v);  chk("R8 status after unarmed stop", v, 32'h0);
        rd(3'd5, v);  chk("R8 tstop after unarmed stop", v, 32'h0);
        wr(3'd0, 32'h4);
        chk("R10 led follows ctrl bit 2", {30'b0, led, dbg_ack}, 32'h2);
        wr(3'd0, 32'h0);

        // R2: sweep of period and high settings
        for (int p = 0; p <= 5; p++) begin
            for (int h = 0; h <= p + 1; h++) begin
                wr(3'd2, 32'(p));
                wr(3'd3, 32'(h));
                wr(3'd0, 32'h1);
                if (h == 0 || h >= p || p <= 1) begin
                    int bad;
                    bad = 0;
                    repeat (2) @(negedge clk);
                    for (int i = 0; i < 3 * p + 4; i++) begin
                        if (dbg_stim !== (h > 0)) bad++;
                        @(negedge clk);
                    end
                    chk($sformatf("R2 constant level p=%0d h=%0d mismatches", p, h), 32'(bad), 32'h0);
                end else begin
                    int nh, nl;
                    nh = 0; nl = 0;
                    while (dbg_stim !== 1'b1) @(negedge clk);
                    while (dbg_stim === 1'b1) begin nh++; @(negedge clk); end
                    while (dbg_stim === 1'b0) begin nl++; @(negedge clk); end
                    chk($sformatf("R2 high run p=%0d h=%0d", p, h), 32'(nh), 32'(h));
                    chk($sformatf("R2 low run p=%0d h=%0d", p, h), 32'(nl), 32'(p - h));
                end
                wr(3'd0, 32'h0);
                @(negedge clk);
                chk("R2 low when disabled", {31'b0, dbg_stim}, 32'h0);
            end
        end

        // clean-up: disarm with one stop, clear flags
        repeat (4) @(negedge clk);
        wr(3'd0, 32'h2);
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h3);
        rd(3'd1, v);
        chk("R7 status after clean-up", v, 32'h4);

        // R3, R4, R6, R7: latency sweep with half period 500
        wr(3'd2, 32'd1000);
        wr(3'd3, 32'd500);
        wr(3'd0, 32'h1);
        ones = 0; zeros = 0;
        foreach (t0[i]) begin end
        for (int k = 0; k < 7; k++) begin
            int d;
            d = (k < 4) ? k : (k == 4 ? 7 : (k == 5 ? 19 : 40));
            wait_stim_change();
            if (dbg_stim) ones++; else zeros++;
            chk("R3 irq not yet set on change cycle", {31'b0, irq}, 32'h0);
            @(negedge clk);
            chk("R3 irq set one cycle after change", {31'b0, irq}, 32'h1);
            chk("R10 dbg_irq follows irq", {31'b0, dbg_irq}, 32'h1);
            repeat (d) @(negedge clk);
            wr(3'd0, 32'h3);
            wr(3'd0, 32'h1);
            wr(3'd1, 32'h0);
            chk("R4 irq kept by zero write", {31'b0, irq}, 32'h1);
            wr(3'd1, 32'h1);
            chk("R4 irq cleared by W1C", {31'b0, irq}, 32'h0);
            rd(3'd6, v);
            chk($sformatf("R7 latency d=%0d", d), v, 32'(d + 1));
            rd(3'd4, t0);
            rd(3'd5, t1);
            chk("R7 tstop minus tstart", t1 - t0, 32'(d + 1));
            rd(3'd1, v);
            chk("R7 status valid only", v, 32'h4);
        end
        chk("R3 rising edges seen", 32'(ones > 0), 32'h1);
        chk("R3 falling edges seen", 32'(zeros > 0), 32'h1);

        // R8: repeat done rising with nothing armed
        rd(3'd5, t1);
        wr(3'd0, 32'h3);
        wr(3'd0, 32'h1);
        rd(3'd5, v);  chk("R8 tstop unchanged", v, t1);
        rd(3'd1, v);  chk("R8 valid kept", v, 32'h4);

        // R5, R6, R9: two changes without service
        wait_stim_change();
        repeat (2) @(negedge clk);
        rd(3'd4, t0);
        rd(3'd1, v);  chk("R9 armed and pending", v, 32'h9);
        wait_stim_change();
        repeat (2) @(negedge clk);
        rd(3'd4, t1);
        chk("R6 tstart spacing equals half period", t1 - t0, 32'd500);
        rd(3'd1, v);  chk("R5/R9 overrun with restart", v, 32'hB);
        wr(3'd1, 32'h2);
        rd(3'd1, v);  chk("R5 overrun cleared alone", v, 32'h9);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule